// File: doc/BRIEF.md
# Interrupt and Timer Control Register

This block is a single 32-bit control/status word reached over a simple memory-mapped bus. It collects up to 32 interrupt source lines into its bits. Each line sets its bit when it rises and clears it when it falls. It drives two outputs: a summarised processor interrupt, gated by one bit of the word, and a separate timer interrupt. An internal divider turns the system clock into a periodic tick. When the timer-enable bit is set, each tick latches a timer-pending flag and raises the timer interrupt. Any bus write to the word acknowledges that interrupt.

The low nibble of the word carries the identifier of the accessing processor, which is taken from an input port on every access. Bit 16 of read data is deliberately unstable: a free-running toggle flop is XORed into it on reads. Only offset 0 of the decoded window holds state. Read data is registered one cycle after the request.

Top module: `irq_timer_csr`

## Requirements
- R1: After reset the word is zero, `cpu_irq_o`, `timer_irq_o` and `bus_rdata_o` are 0, and the toggle flop is 0.
- R2: A rising edge on `src_i[n]` sets bit n of the word and a falling edge clears it, for n = 0..31. Edges are applied after a same-cycle bus write, so they override the written value for that bit.
- R3: `cpu_irq_o` is 1 exactly when the stored bit 28 (gate) is 1 and at least one stored bit selected by `IRQ_SUM_MASK` is 1. The default mask is 0xCFFE7FF0, which excludes bits 3:0, 15, 16, 28 and 29. The output follows the register in the same cycle and is never 1 while bit 28 is 0.
- R4: A tick occurs once every `TICK_DIV` clock cycles. At a tick where stored bit 15 (timer enable) is 1, bit 29 (timer pending) and `timer_irq_o` are set on that edge. With bit 15 at 0, ticks have no effect.
- R5: A write at offset 0 loads `bus_wdata_i` into bits 31:4 and clears bit 29 and `timer_irq_o`. A tick with the enable set on that same edge sets them again, so the tick wins.
- R6: A read at offset 0 returns the word, with bits 3:0 replaced by `cpu_id_i`, on `bus_rdata_o` in the following cycle. Any access at offset 0 also stores `cpu_id_i` into bits 3:0.
- R7: Bit 16 of read data is the stored bit 16 XOR a toggle flop that inverts on every clock. Two reads in consecutive cycles of an unchanged word therefore differ in bit 16.
- R8: Reads at any nonzero offset return 0, and writes at a nonzero offset change neither the word nor `timer_irq_o`.
- R9: `bus_rdata_o` is 0 in every cycle that does not follow a read at offset 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_id_i | input | 4 | Identifier of the accessing processor |
| src_i | input | 32 | Interrupt source lines, one per bit |
| bus_valid_i | input | 1 | Bus request valid for this cycle |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte offset inside the window |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, one cycle after the request |
| cpu_irq_o | output | 1 | Gated summary processor interrupt |
| timer_irq_o | output | 1 | Timer interrupt |

## Verification
Several properties are checked on every cycle:
- the gate relation of `cpu_irq_o`;
- that the timer output can only rise with the enable bit set, and always together with the pending bit;
- that a write without a coinciding enabled tick drops the timer output;
- that source edges land in the word;
- that idle cycles leave read data at zero;
- the identifier nibble of read data.

Some behaviour only the bench scenarios can show:
- the exact tick spacing;
- the alternation of bit 16 across back-to-back reads;
- that accesses at other offsets leave the word untouched;
- the full read-data value under random mixes of writes, reads and source edges, checked against a reference model.

// File: rtl/irq_csr_pkg.sv
package irq_csr_pkg;
  localparam int unsigned DATA_W       = 32;
  localparam int unsigned ID_W         = 4;
  localparam int unsigned BIT_TMR_EN   = 15;
  localparam int unsigned BIT_JITTER   = 16;
  localparam int unsigned BIT_GATE     = 28;
  localparam int unsigned BIT_TMR_PEND = 29;
  localparam logic [DATA_W-1:0] DEF_SUM_MASK = 32'hCFFE_7FF0;

  typedef logic [DATA_W-1:0] word_t;
endpackage

// File: rtl/irq_tick_div.sv
module irq_tick_div #(
  parameter int unsigned TICK_DIV = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CNT_W = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_DIV - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/irq_src_edge.sv
module irq_src_edge #(
  parameter int unsigned N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] src_i,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] src_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) src_q <= '0;
    else         src_q <= src_i;
  end

  for (genvar i = 0; i < N; i++) begin : g_edge
    assign rise_o[i] = src_i[i] & ~src_q[i];
    assign fall_o[i] = ~src_i[i] & src_q[i];
  end
endmodule

// File: rtl/irq_csr_core.sv
module irq_csr_core
  import irq_csr_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic            rd_i,
  input  word_t           wdata_i,
  input  logic [ID_W-1:0] cpu_id_i,
  input  word_t           rise_i,
  input  word_t           fall_i,
  input  logic            tick_i,
  output word_t           csr_o,
  output logic            timer_irq_o
);
  word_t csr_q, csr_d;
  logic  tmr_q;
  logic  tmr_fire;

  assign tmr_fire = tick_i & csr_q[BIT_TMR_EN];

  always_comb begin
    csr_d = csr_q;
    if (wr_i) begin
      csr_d               = wdata_i;
      csr_d[ID_W-1:0]     = cpu_id_i;
      csr_d[BIT_TMR_PEND] = 1'b0;
    end else if (rd_i) begin
      csr_d[ID_W-1:0] = cpu_id_i;
    end
    // source edges win over a same-cycle write
    csr_d = (csr_d | rise_i) & ~fall_i;
    // tick wins over the write acknowledge
    if (tmr_fire) csr_d[BIT_TMR_PEND] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      csr_q <= '0;
      tmr_q <= 1'b0;
    end else begin
      csr_q <= csr_d;
      if (tmr_fire)  tmr_q <= 1'b1;
      else if (wr_i) tmr_q <= 1'b0;
    end
  end

  assign csr_o       = csr_q;
  assign timer_irq_o = tmr_q;
endmodule

// File: rtl/irq_timer_csr.sv
module irq_timer_csr
  import irq_csr_pkg::*;
#(
  parameter int unsigned ADDR_W       = 12,
  parameter int unsigned TICK_DIV     = 16,
  parameter logic [31:0] IRQ_SUM_MASK = DEF_SUM_MASK
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        cpu_id_i,
  input  logic [31:0]       src_i,
  input  logic              bus_valid_i,
  input  logic              bus_write_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              cpu_irq_o,
  output logic              timer_irq_o
);
  logic  hit0, wr0, rd0;
  logic  tick;
  logic  jit_q;
  word_t src_rise, src_fall;
  word_t csr_q;
  word_t rdata_q;

  assign hit0 = bus_valid_i & (bus_addr_i == '0);
  assign wr0  = hit0 & bus_write_i;
  assign rd0  = hit0 & ~bus_write_i;

  irq_tick_div #(.TICK_DIV(TICK_DIV)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  irq_src_edge #(.N(DATA_W)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .src_i  (src_i),
    .rise_o (src_rise),
    .fall_o (src_fall)
  );

  irq_csr_core u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (wr0),
    .rd_i        (rd0),
    .wdata_i     (bus_wdata_i),
    .cpu_id_i    (cpu_id_i),
    .rise_i      (src_rise),
    .fall_i      (src_fall),
    .tick_i      (tick),
    .csr_o       (csr_q),
    .timer_irq_o (timer_irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      jit_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      jit_q <= ~jit_q;
      if (rd0) begin
        rdata_q             <= {csr_q[DATA_W-1:ID_W], cpu_id_i};
        rdata_q[BIT_JITTER] <= csr_q[BIT_JITTER] ^ jit_q;
      end else begin
        rdata_q <= '0;
      end
    end
  end

  assign bus_rdata_o = rdata_q;
  assign cpu_irq_o   = csr_q[BIT_GATE] & |(csr_q & IRQ_SUM_MASK);
endmodule

// File: rtl/irq_timer_csr_chk.sv
module irq_timer_csr_chk #(
  parameter int unsigned ADDR_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [3:0]        cpu_id_i,
  input logic              bus_valid_i,
  input logic              bus_write_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [31:0]       bus_rdata_o,
  input logic [31:0]       csr_q,
  input logic [31:0]       src_rise,
  input logic [31:0]       src_fall,
  input logic              tick,
  input logic              cpu_irq_o,
  input logic              timer_irq_o
);
  logic rd0, wr0;
  assign rd0 = bus_valid_i & ~bus_write_i & (bus_addr_i == '0);
  assign wr0 = bus_valid_i &  bus_write_i & (bus_addr_i == '0);

  // R3
  gate_blocks_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_irq_o |-> csr_q[28]);

  // R4
  timer_needs_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timer_irq_o) |-> ($past(csr_q[15]) && csr_q[29]));

  // R5
  write_acks_timer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr0 && !(tick && csr_q[15])) |=> !timer_irq_o);

  // R2
  rise_sets_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_rise != '0) |=> ((csr_q & $past(src_rise)) == $past(src_rise)));

  // R2
  fall_clears_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_fall != '0) |=> ((csr_q & $past(src_fall) & ~32'h2000_0000) == '0));

  // R9
  idle_rdata_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd0 |=> (bus_rdata_o == '0));

  // R6
  read_id_nibble_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd0 |=> (bus_rdata_o[3:0] == $past(cpu_id_i)));
endmodule

bind irq_timer_csr irq_timer_csr_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cpu_id_i    (cpu_id_i),
  .bus_valid_i (bus_valid_i),
  .bus_write_i (bus_write_i),
  .bus_addr_i  (bus_addr_i),
  .bus_rdata_o (bus_rdata_o),
  .csr_q       (csr_q),
  .src_rise    (src_rise),
  .src_fall    (src_fall),
  .tick        (tick),
  .cpu_irq_o   (cpu_irq_o),
  .timer_irq_o (timer_irq_o)
);

// File: tb/irq_timer_csr_tb.sv
module irq_timer_csr_tb;
  localparam int          CLK_PERIOD = 10;
  localparam int          ADDR_W     = 12;
  localparam int          TICK_DIV   = 16;
  localparam logic [31:0] SUM_MASK   = 32'hCFFE_7FF0;
  localparam logic [31:0] NO_JIT     = ~32'h0001_0000;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic [3:0]        cpu_id_i = '0;
  logic [31:0]       src_i = '0;
  logic              bus_valid_i = 1'b0;
  logic              bus_write_i = 1'b0;
  logic [ADDR_W-1:0] bus_addr_i = '0;
  logic [31:0]       bus_wdata_i = '0;
  logic [31:0]       bus_rdata_o;
  logic              cpu_irq_o, timer_irq_o;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  logic [31:0] model = '0;
  logic [31:0] src_prev = '0;

  irq_timer_csr #(.ADDR_W(ADDR_W), .TICK_DIV(TICK_DIV), .IRQ_SUM_MASK(SUM_MASK)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .cpu_id_i(cpu_id_i), .src_i(src_i),
    .bus_valid_i(bus_valid_i), .bus_write_i(bus_write_i), .bus_addr_i(bus_addr_i),
    .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
    .cpu_irq_o(cpu_irq_o), .timer_irq_o(timer_irq_o));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] next_word(input logic [31:0] pre, input bit v, input bit w,
      input logic [ADDR_W-1:0] a, input logic [31:0] d, input logic [31:0] s,
      input logic [31:0] sp, input logic [3:0] id);
    logic [31:0] n = pre;
    if (v && a == '0) begin
      if (w) begin n = d; n[29] = 1'b0; end
      n[3:0] = id;
    end
    n = (n | (s & ~sp)) & ~(~s & sp);
    return n;
  endfunction

  function automatic logic exp_irq(input logic [31:0] wd);
    return wd[28] & |(wd & SUM_MASK);
  endfunction

  // one bus cycle, starting and ending at a falling edge, checked against the model
  task automatic step(input string req, input bit v, input bit w, input logic [ADDR_W-1:0] a,
      input logic [31:0] d, input logic [31:0] s, input logic [3:0] id);
    logic [31:0] rd_exp;
    bus_valid_i = v; bus_write_i = w; bus_addr_i = a; bus_wdata_i = d;
    src_i = s; cpu_id_i = id;
    rd_exp = (v && !w && a == '0) ? {model[31:4], id} : 32'h0;
    model = next_word(model, v, w, a, d, s, src_prev, id);
    src_prev = s;
    @(negedge clk);
    bus_valid_i = 1'b0;
    chk(req, bus_rdata_o & NO_JIT, rd_exp & NO_JIT);
    chk("R3", {31'b0, cpu_irq_o}, {31'b0, exp_irq(model)});
    chk("R4", {31'b0, timer_irq_o}, 32'h0);
  endtask

  // unchecked bus cycle
  task automatic raw(input bit v, input bit w, input logic [ADDR_W-1:0] a, input logic [31:0] d);
    bus_valid_i = v; bus_write_i = w; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk);
    bus_valid_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int t1, t2, n;
    logic b1, b2;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", bus_rdata_o, 32'h0);
    chk("R1", {31'b0, cpu_irq_o}, 32'h0);
    chk("R1", {31'b0, timer_irq_o}, 32'h0);
    step("R1", 1, 0, '0, 0, 0, 4'h5);
    step("R6", 0, 0, '0, 0, 0, 4'h5);
    step("R6", 1, 0, '0, 0, 0, 4'hA);

    // R2 rise sets, fall clears
    step("R2", 0, 0, '0, 0, 32'h0010_0000, 4'h3);
    step("R2", 1, 0, '0, 0, 32'h0010_0000, 4'h3);
    // R3 gate on with a summary bit present
    step("R3", 1, 1, '0, 32'h1010_0000, 32'h0010_0000, 4'h3);
    step("R3", 1, 0, '0, 0, 32'h0010_0000, 4'h3);
    step("R2", 0, 0, '0, 0, 32'h0000_0000, 4'h3);
    step("R3", 1, 0, '0, 0, 0, 4'h3);
    // R3 gate set but only unsummarised bits
    step("R3", 1, 1, '0, 32'h1001_800F, 0, 4'h3);
    step("R3", 1, 1, '0, 32'h0000_0000, 0, 4'h3);
    // R2 fall overrides a same-cycle write of that bit
    step("R2", 0, 0, '0, 0, 32'h0020_0000, 4'h1);
    step("R2", 1, 1, '0, 32'h1020_0000, 32'h0000_0000, 4'h1);
    step("R2", 1, 0, '0, 0, 0, 4'h1);
    // R2 rise overrides a same-cycle write clearing that bit
    step("R2", 1, 1, '0, 32'h1000_0000, 32'h0040_0000, 4'h1);
    step("R2", 1, 0, '0, 0, 32'h0040_0000, 4'h1);

    // R8 nonzero offsets
    step("R8", 1, 1, 12'h010, 32'hFFFF_FFF0, 32'h0040_0000, 4'h2);
    step("R8", 1, 0, 12'h010, 0, 32'h0040_0000, 4'h2);
    step("R8", 1, 0, 12'h004, 0, 32'h0040_0000, 4'h2);
    step("R8", 1, 0, '0, 0, 32'h0040_0000, 4'h2);
    step("R9", 0, 0, '0, 0, 32'h0040_0000, 4'h2);

    // R7 back-to-back reads differ in bit 16
    bus_valid_i = 1'b1; bus_write_i = 1'b0; bus_addr_i = '0;
    @(negedge clk); b1 = bus_rdata_o[16];
    @(negedge clk); b2 = bus_rdata_o[16];
    bus_valid_i = 1'b0;
    chk("R7", {31'b0, b1 ^ b2}, 32'h1);
    step("R9", 0, 0, '0, 0, 32'h0040_0000, 4'h2);

    // random phase: bit 15 kept clear so no timer activity
    for (int i = 0; i < 3000; i++) begin
      int op;
      logic [31:0] s;
      logic [ADDR_W-1:0] a;
      op = $urandom_range(0, 5);
      s  = src_prev;
      if ($urandom_range(0, 2) == 0) s = s ^ ((32'h1 << $urandom_range(0, 31)) & ~32'h0000_8000);
      a  = (op == 3 || op == 4) ? ADDR_W'($urandom_range(1, 255)) : '0;
      case (op)
        1, 5: step("R5", 1, 1, '0, $urandom() & ~32'h0000_8000, s, 4'($urandom()));
        2:    step("R6", 1, 0, '0, 0, s, 4'($urandom()));
        3:    step("R8", 1, 0, a, 0, s, 4'($urandom()));
        4:    step("R8", 1, 1, a, $urandom(), s, 4'($urandom()));
        default: step("R9", 0, 0, '0, 0, s, cpu_id_i);
      endcase
    end

    // clear sources and word, then timer scenario
    step("R2", 0, 0, '0, 0, 0, 4'h0);
    step("R5", 1, 1, '0, 0, 0, 4'h0);
    step("R4", 0, 0, '0, 0, 0, 4'h0);
    // disabled timer: no interrupt over several tick periods
    for (int i = 0; i < 3 * TICK_DIV; i++) step("R4", 0, 0, '0, 0, 0, 4'h0);

    raw(1, 1, '0, 32'h0000_8000);
    n = 0;
    while (!timer_irq_o && n < 4 * TICK_DIV) begin raw(0, 0, '0, 0); n++; end
    chk("R4", {31'b0, timer_irq_o}, 32'h1);
    chk("R4", {31'b0, n <= TICK_DIV}, 32'h1);
    t1 = cyc;
    raw(1, 0, '0, 0);
    chk("R4", bus_rdata_o & 32'h2000_8000, 32'h2000_8000);
    raw(1, 1, '0, 32'h0000_8000);
    chk("R5", {31'b0, timer_irq_o}, 32'h0);
    raw(1, 0, '0, 0);
    chk("R5", bus_rdata_o & 32'h2000_8000, 32'h0000_8000);
    n = 0;
    while (!timer_irq_o && n < 4 * TICK_DIV) begin raw(0, 0, '0, 0); n++; end
    t2 = cyc;
    chk("R4", t2 - t1, TICK_DIV);
    // write at nonzero offset does not acknowledge
    raw(1, 1, 12'h020, 32'h0);
    chk("R8", {31'b0, timer_irq_o}, 32'h1);
    raw(1, 1, '0, 32'h0);
    raw(1, 1, '0, 32'h0);
    chk("R5", {31'b0, timer_irq_o}, 32'h0);
    model = 32'h0;
    step("R6", 1, 0, '0, 0, 0, 4'h7);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule